// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the instructions of an out-of-order core in their issue order. Each issued instruction gets an entry in a circular buffer, and the entry number serves as the tag for its result. Execution units broadcast finished results on a result bus, tagged with that entry number. The matching entry captures the value and is marked complete. Later instructions can read a completed but not yet retired value by presenting its tag on a lookup port.

Retirement is strictly in order, one entry per cycle, and only from the oldest entry once it is complete. A register operation writes the register file and a store writes memory. A branch whose result reported a wrong prediction discards every younger entry and sends out the correct fetch address. An exception recorded against an entry stays silent until that entry is the oldest. It then takes effect as a precise exception: nothing is written and every entry is discarded.

Top module: `rob_core`

## Requirements
- R1: An issue request is accepted when `iss_ready_o` is high. The new entry takes the tag shown on `iss_tag_o`, and successive accepted issues take successive tags modulo DEPTH. With DEPTH entries held, `iss_ready_o` is low and a request is dropped.
- R2: `count_o` gives the number of held entries. `full_o` is high exactly at DEPTH entries and `empty_o` exactly at zero. After reset the buffer is empty.
- R3: A result with `wb_valid_i` high marks the held entry whose index equals `wb_tag_i` as complete and stores `wb_value_i`. A result aimed at a free entry changes nothing.
- R4: Lookup port k reports `look_hit_o[k]`=1 and the stored value when entry `look_tag_i[k]` is held and complete; otherwise it reports 0. A result arriving in the same cycle is not yet visible.
- R5: Retirement takes only the oldest entry and only once it is complete, at most one per cycle. A complete younger entry waits behind an incomplete older one.
- R6: Retiring a register operation (kind code 2'b00) gives a one-cycle `rf_we_o` pulse after the retiring edge, with `rf_addr_o` set to the register index given at issue and `rf_data_o` set to the result.
- R7: Retiring a store (kind code 2'b01) gives a one-cycle `mem_we_o` pulse, with `mem_addr_o` set to the `wb_addr_i` delivered with its result and `mem_data_o` set to its value.
- R8: Retiring a branch (kind code 2'b10) writes nothing. If its result carried `wb_mispredict_i`, the block pulses `flush_o` for one cycle, puts the result value on `redirect_pc_o`, and discards all entries, so the buffer is empty. An issue request in the retiring cycle is dropped.
- R9: A result with `wb_excp_i` only marks the entry. When that entry retires, `excp_o` and `flush_o` pulse, no register or memory write happens, and the buffer empties.
- R10: A result written to the oldest entry is not retired in the same cycle; retirement happens at the following edge at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid_i | input | 1 | Issue request |
| iss_kind_i | input | 2 | Kind: 00 register op, 01 store, 10 branch |
| iss_reg_i | input | REG_W | Destination register of a register op |
| iss_ready_o | output | 1 | A free entry exists |
| iss_tag_o | output | TAG_W | Tag the next accepted issue receives |
| wb_valid_i | input | 1 | Result bus valid |
| wb_tag_i | input | TAG_W | Entry the result belongs to |
| wb_value_i | input | DATA_W | Result value, store data or correct branch target |
| wb_addr_i | input | ADDR_W | Store address |
| wb_mispredict_i | input | 1 | Branch was mispredicted |
| wb_excp_i | input | 1 | Instruction raised an exception |
| look_tag_i | input | NLOOK x TAG_W | Operand lookup tags |
| look_hit_o | output | NLOOK | Lookup found a complete entry |
| look_value_o | output | NLOOK x DATA_W | Forwarded values |
| rf_we_o | output | 1 | Register file write pulse |
| rf_addr_o | output | REG_W | Register file index |
| rf_data_o | output | DATA_W | Register file data |
| mem_we_o | output | 1 | Memory write pulse |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_data_o | output | DATA_W | Memory data |
| flush_o | output | 1 | Discard pulse |
| redirect_pc_o | output | DATA_W | Correct fetch address after a mispredict |
| excp_o | output | 1 | Precise exception pulse |
| count_o | output | CNT_W | Held entries |
| full_o | output | 1 | All entries held |
| empty_o | output | 1 | No entry held |

## Verification
The hardest case to reach is a discard that happens while the buffer holds complete younger entries and a new issue arrives in the same cycle. The stimulus first issues a mispredicted branch, then issues younger instructions and completes them. It delivers the branch result last and holds an issue request on the exact retiring edge. A second directed sequence fills the buffer, completes a younger entry before the oldest, and completes the oldest alone. This shows the in-order wait and the one-cycle delay of a result written to the oldest entry. Random traffic with rare exceptions and mispredicts then moves the pointers around the ring many times, so discards happen at every head position.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'b00,
    K_STORE  = 2'b01,
    K_BRANCH = 2'b10
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      // the flushing entry retires; everything behind it is dropped
      head  <= head + TAG_W'(1);
      tail  <= head + TAG_W'(1);
      count <= '0;
    end else begin
      if (push) tail <= tail + TAG_W'(1);
      if (pop)  head <= head + TAG_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rob_slots.sv
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int NLOOK  = 2,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc,
  input  logic [TAG_W-1:0]              alloc_idx,
  input  rob_kind_e                     alloc_kind,
  input  logic [ADDR_W-1:0]             alloc_dest,
  input  logic                          wb_valid,
  input  logic [TAG_W-1:0]              wb_tag,
  input  logic [DATA_W-1:0]             wb_value,
  input  logic [ADDR_W-1:0]             wb_addr,
  input  logic                          wb_mis,
  input  logic                          wb_excp,
  input  logic                          free,
  input  logic                          flush_all,
  input  logic [TAG_W-1:0]              head_idx,
  output logic                          head_valid,
  output logic                          head_ready,
  output rob_kind_e                     head_kind,
  output logic [ADDR_W-1:0]             head_dest,
  output logic [DATA_W-1:0]             head_value,
  output logic                          head_mis,
  output logic                          head_excp,
  input  logic [NLOOK-1:0][TAG_W-1:0]   look_tag,
  output logic [NLOOK-1:0]              look_hit,
  output logic [NLOOK-1:0][DATA_W-1:0]  look_value
);
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  ready_q;
  rob_kind_e         kind_q  [DEPTH];
  logic [ADDR_W-1:0] dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic [DEPTH-1:0]  mis_q;
  logic [DEPTH-1:0]  excp_q;
  logic              wb_hit;

  assign wb_hit = wb_valid && valid_q[wb_tag] && !flush_all;

  // control bits: reset and cleared on discard
  always_ff @(posedge clk) begin
    if (rst || flush_all) begin
      valid_q <= '0;
      ready_q <= '0;
    end else begin
      if (free) valid_q[head_idx] <= 1'b0;
      if (alloc) begin
        valid_q[alloc_idx] <= 1'b1;
        ready_q[alloc_idx] <= 1'b0;
      end
      if (wb_hit) ready_q[wb_tag] <= 1'b1;
    end
  end

  // payload: no reset, qualified by the control bits
  always_ff @(posedge clk) begin
    if (alloc) begin
      kind_q[alloc_idx] <= alloc_kind;
      dest_q[alloc_idx] <= alloc_dest;
      mis_q[alloc_idx]  <= 1'b0;
      excp_q[alloc_idx] <= 1'b0;
    end
    if (wb_hit) begin
      value_q[wb_tag] <= wb_value;
      mis_q[wb_tag]   <= wb_mis;
      excp_q[wb_tag]  <= wb_excp;
      if (kind_q[wb_tag] == K_STORE) dest_q[wb_tag] <= wb_addr;
    end
  end

  assign head_valid = valid_q[head_idx];
  assign head_ready = ready_q[head_idx];
  assign head_kind  = kind_q[head_idx];
  assign head_dest  = dest_q[head_idx];
  assign head_value = value_q[head_idx];
  assign head_mis   = mis_q[head_idx];
  assign head_excp  = excp_q[head_idx];

  for (genvar g = 0; g < NLOOK; g++) begin : g_look
    assign look_hit[g]   = valid_q[look_tag[g]] && ready_q[look_tag[g]];
    assign look_value[g] = value_q[look_tag[g]];
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic              head_ready,
  input  rob_kind_e         head_kind,
  input  logic [ADDR_W-1:0] head_dest,
  input  logic [DATA_W-1:0] head_value,
  input  logic              head_mis,
  input  logic              head_excp,
  output logic              commit,
  output logic              flush_now,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_addr_o,
  output logic [DATA_W-1:0] rf_data_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] redirect_pc_o,
  output logic              excp_o
);
  logic redirect;

  assign commit    = head_valid && head_ready;
  assign redirect  = commit && !head_excp && head_kind == K_BRANCH && head_mis;
  assign flush_now = redirect || (commit && head_excp);

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we_o       <= 1'b0;
      rf_addr_o     <= '0;
      rf_data_o     <= '0;
      mem_we_o      <= 1'b0;
      mem_addr_o    <= '0;
      mem_data_o    <= '0;
      flush_o       <= 1'b0;
      redirect_pc_o <= '0;
      excp_o        <= 1'b0;
    end else begin
      rf_we_o  <= commit && !head_excp && head_kind == K_REG;
      mem_we_o <= commit && !head_excp && head_kind == K_STORE;
      flush_o  <= flush_now;
      excp_o   <= commit && head_excp;
      if (commit) begin
        rf_addr_o  <= head_dest[REG_W-1:0];
        rf_data_o  <= head_value;
        mem_addr_o <= head_dest;
        mem_data_o <= head_value;
      end
      if (redirect) redirect_pc_o <= head_value;
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  parameter int NLOOK  = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          iss_valid_i,
  input  logic [1:0]                    iss_kind_i,
  input  logic [REG_W-1:0]              iss_reg_i,
  output logic                          iss_ready_o,
  output logic [TAG_W-1:0]              iss_tag_o,
  input  logic                          wb_valid_i,
  input  logic [TAG_W-1:0]              wb_tag_i,
  input  logic [DATA_W-1:0]             wb_value_i,
  input  logic [ADDR_W-1:0]             wb_addr_i,
  input  logic                          wb_mispredict_i,
  input  logic                          wb_excp_i,
  input  logic [NLOOK-1:0][TAG_W-1:0]   look_tag_i,
  output logic [NLOOK-1:0]              look_hit_o,
  output logic [NLOOK-1:0][DATA_W-1:0]  look_value_o,
  output logic                          rf_we_o,
  output logic [REG_W-1:0]              rf_addr_o,
  output logic [DATA_W-1:0]             rf_data_o,
  output logic                          mem_we_o,
  output logic [ADDR_W-1:0]             mem_addr_o,
  output logic [DATA_W-1:0]             mem_data_o,
  output logic                          flush_o,
  output logic [DATA_W-1:0]             redirect_pc_o,
  output logic                          excp_o,
  output logic [CNT_W-1:0]              count_o,
  output logic                          full_o,
  output logic                          empty_o
);
  logic              push, commit, flush_now;
  logic [TAG_W-1:0]  head, tail;
  rob_kind_e         kind_in;
  logic [ADDR_W-1:0] dest_in;
  logic              h_valid, h_ready, h_mis, h_excp;
  rob_kind_e         h_kind;
  logic [ADDR_W-1:0] h_dest;
  logic [DATA_W-1:0] h_value;

  assign kind_in     = rob_kind_e'(iss_kind_i);
  assign dest_in     = (kind_in == K_REG) ? ADDR_W'(iss_reg_i) : '0;
  assign push        = iss_valid_i && !full_o && !flush_now;
  assign iss_ready_o = !full_o;
  assign iss_tag_o   = tail;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(commit), .flush(flush_now),
    .head(head), .tail(tail), .count(count_o), .full(full_o), .empty(empty_o)
  );

  rob_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NLOOK(NLOOK)) u_slots (
    .clk(clk), .rst(rst),
    .alloc(push), .alloc_idx(tail), .alloc_kind(kind_in), .alloc_dest(dest_in),
    .wb_valid(wb_valid_i), .wb_tag(wb_tag_i), .wb_value(wb_value_i),
    .wb_addr(wb_addr_i), .wb_mis(wb_mispredict_i), .wb_excp(wb_excp_i),
    .free(commit), .flush_all(flush_now), .head_idx(head),
    .head_valid(h_valid), .head_ready(h_ready), .head_kind(h_kind),
    .head_dest(h_dest), .head_value(h_value), .head_mis(h_mis), .head_excp(h_excp),
    .look_tag(look_tag_i), .look_hit(look_hit_o), .look_value(look_value_o)
  );

  rob_retire #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_retire (
    .clk(clk), .rst(rst),
    .head_valid(h_valid), .head_ready(h_ready), .head_kind(h_kind),
    .head_dest(h_dest), .head_value(h_value), .head_mis(h_mis), .head_excp(h_excp),
    .commit(commit), .flush_now(flush_now),
    .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o), .rf_data_o(rf_data_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .flush_o(flush_o), .redirect_pc_o(redirect_pc_o), .excp_o(excp_o)
  );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rf_we_o,
  input logic             mem_we_o,
  input logic             flush_o,
  input logic             excp_o,
  input logic [CNT_W-1:0] count_o,
  input logic             full_o,
  input logic             empty_o
);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count_o <= CNT_W'(DEPTH));

  p_full_not_empty_r2: assert property (@(posedge clk) disable iff (rst)
    full_o |-> !empty_o);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count_o <= $past(count_o) + CNT_W'(1));

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    full_o |=> count_o <= $past(count_o));

  p_one_retire_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we_o, mem_we_o, excp_o}));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> empty_o);

  p_quiet_after_flush_r8: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !rf_we_o && !mem_we_o && !flush_o);

  p_excp_flushes_r9: assert property (@(posedge clk) disable iff (rst)
    excp_o |-> flush_o && !rf_we_o && !mem_we_o);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rf_we_o(rf_we_o), .mem_we_o(mem_we_o),
  .flush_o(flush_o), .excp_o(excp_o), .count_o(count_o),
  .full_o(full_o), .empty_o(empty_o)
);

// File: tb/rob_core_bench.sv
`timescale 1ns/1ps
module rob_core_bench;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic            iss_valid_i = 0;
  logic [1:0]      iss_kind_i = 0;
  logic [4:0]      iss_reg_i = 0;
  logic            iss_ready_o;
  logic [2:0]      iss_tag_o;
  logic            wb_valid_i = 0;
  logic [2:0]      wb_tag_i = 0;
  logic [31:0]     wb_value_i = 0;
  logic [31:0]     wb_addr_i = 0;
  logic            wb_mispredict_i = 0;
  logic            wb_excp_i = 0;
  logic [1:0][2:0] look_tag_i = '0;
  logic [1:0]      look_hit_o;
  logic [1:0][31:0] look_value_o;
  logic            rf_we_o, mem_we_o, flush_o, excp_o, full_o, empty_o;
  logic [4:0]      rf_addr_o;
  logic [31:0]     rf_data_o, mem_addr_o, mem_data_o, redirect_pc_o;
  logic [3:0]      count_o;

  rob_core u_rob_core (.*);

  int n_checks = 0;
  int n_errors = 0;

  // bench model of the buffer
  bit        m_valid [D];
  bit        m_ready [D];
  int        m_kind  [D];
  logic [31:0] m_dest [D];
  logic [31:0] m_val  [D];
  bit        m_mis   [D];
  bit        m_exc   [D];
  int        m_head = 0, m_tail = 0, m_cnt = 0;
  bit        e_rf, e_mem, e_flush, e_excp;
  logic [31:0] e_rf_addr, e_data, e_addr, e_redir;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bit commit, fl, acc;
    int h;
    h = m_head;
    commit = m_valid[h] && m_ready[h];
    e_rf = 0; e_mem = 0; e_flush = 0; e_excp = 0;
    if (commit) begin
      e_rf_addr = m_dest[h]; e_addr = m_dest[h]; e_data = m_val[h];
      if (m_exc[h]) begin e_excp = 1; e_flush = 1; end
      else if (m_kind[h] == 0) e_rf = 1;
      else if (m_kind[h] == 1) e_mem = 1;
      else if (m_kind[h] == 2 && m_mis[h]) begin e_flush = 1; e_redir = m_val[h]; end
    end
    fl  = e_flush;
    acc = iss_valid_i && (m_cnt < D) && !fl;
    if (!fl && wb_valid_i && m_valid[wb_tag_i]) begin
      m_ready[wb_tag_i] = 1; m_val[wb_tag_i] = wb_value_i;
      m_mis[wb_tag_i] = wb_mispredict_i; m_exc[wb_tag_i] = wb_excp_i;
      if (m_kind[wb_tag_i] == 1) m_dest[wb_tag_i] = wb_addr_i;
    end
    if (fl) begin
      for (int i = 0; i < D; i++) m_valid[i] = 0;
      m_head = (h + 1) % D; m_tail = m_head; m_cnt = 0;
    end else begin
      if (commit) begin m_valid[h] = 0; m_head = (h + 1) % D; m_cnt--; end
      if (acc) begin
        m_valid[m_tail] = 1; m_ready[m_tail] = 0; m_mis[m_tail] = 0; m_exc[m_tail] = 0;
        m_kind[m_tail] = int'(iss_kind_i);
        m_dest[m_tail] = (iss_kind_i == 2'b00) ? {27'd0, iss_reg_i} : 32'd0;
        m_tail = (m_tail + 1) % D; m_cnt++;
      end
    end
  endtask

  // one cycle: inputs already set at the falling edge
  task automatic step();
    #1;
    chk("R1 tag", iss_tag_o, m_tail);
    chk("R1 ready", iss_ready_o, m_cnt < D);
    for (int k = 0; k < 2; k++) begin
      chk("R4 hit", look_hit_o[k], m_valid[look_tag_i[k]] && m_ready[look_tag_i[k]]);
      if (m_valid[look_tag_i[k]] && m_ready[look_tag_i[k]])
        chk("R4 value", look_value_o[k], m_val[look_tag_i[k]]);
    end
    model_edge();
    @(posedge clk); #1;
    chk("R6 rf_we", rf_we_o, e_rf);
    if (e_rf) begin
      chk("R6 rf_addr", rf_addr_o, e_rf_addr[4:0]);
      chk("R6 rf_data", rf_data_o, e_data);
    end
    chk("R7 mem_we", mem_we_o, e_mem);
    if (e_mem) begin
      chk("R7 mem_addr", mem_addr_o, e_addr);
      chk("R7 mem_data", mem_data_o, e_data);
    end
    chk("R8 flush", flush_o, e_flush);
    if (e_flush && !e_excp) chk("R8 redirect", redirect_pc_o, e_redir);
    chk("R9 excp", excp_o, e_excp);
    chk("R2 count", count_o, m_cnt);
    chk("R2 full", full_o, m_cnt == D);
    chk("R2 empty", empty_o, m_cnt == 0);
    @(negedge clk);
  endtask

  task automatic clear_in();
    iss_valid_i = 0; wb_valid_i = 0; wb_mispredict_i = 0; wb_excp_i = 0;
  endtask

  task automatic issue(input logic [1:0] kind, input logic [4:0] r);
    clear_in(); iss_valid_i = 1; iss_kind_i = kind; iss_reg_i = r; step();
  endtask

  task automatic wb(input int tag, input logic [31:0] v, input logic [31:0] a,
                    input bit mis, input bit exc);
    clear_in(); wb_valid_i = 1; wb_tag_i = 3'(tag); wb_value_i = v; wb_addr_i = a;
    wb_mispredict_i = mis; wb_excp_i = exc; step();
  endtask

  task automatic idle();
    clear_in(); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    int seed, tb_, tr, ts, t;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < D; i++) begin
      m_valid[i] = 0; m_ready[i] = 0; m_kind[i] = 0; m_dest[i] = 0;
      m_val[i] = 0; m_mis[i] = 0; m_exc[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R2 reset empty", empty_o, 1);
    chk("R2 reset count", count_o, 0);
    idle();

    // fill, then try one more (R1)
    for (int i = 0; i < D; i++) issue(2'b00, 5'(i + 1));
    issue(2'b00, 5'd31);
    chk("R1 issue dropped when full", count_o, D);

    // younger complete entry waits (R5)
    wb(2, 32'hC0DE_0002, 0, 0, 0);
    idle();
    chk("R5 younger waits", rf_we_o, 0);
    // result to head not retired in same edge (R10)
    wb(0, 32'hC0DE_0000, 0, 0, 0);
    chk("R10 no same-cycle retire", rf_we_o, 0);
    idle();
    chk("R10 retire next cycle", rf_we_o, 1);
    chk("R10 retire data", rf_data_o, 32'hC0DE_0000);
    idle();
    chk("R5 head incomplete", rf_we_o, 0);
    wb(1, 32'hC0DE_0001, 0, 0, 0);
    idle();
    idle();
    chk("R5 in-order second", rf_addr_o, 3);

    // exception at head (R9)
    wb(3, 32'h1, 0, 0, 1);
    idle();
    chk("R9 excp pulse", excp_o, 1);
    chk("R9 no write", rf_we_o, 0);
    chk("R9 emptied", count_o, 0);

    // result to a free entry is ignored (R3)
    wb(5, 32'hDEAD, 0, 0, 0);
    clear_in(); look_tag_i[0] = 3'd5; step();
    chk("R3 free entry stays free", look_hit_o[0], 0);
    chk("R3 count unchanged", count_o, 0);

    // mispredicted branch with younger complete work and issue at the flush edge (R8)
    tb_ = m_tail; issue(2'b10, 0);
    tr = m_tail;  issue(2'b00, 5'd7);
    ts = m_tail;  issue(2'b01, 0);
    wb(tr, 32'h77, 0, 0, 0);
    wb(ts, 32'h88, 32'h400, 0, 0);
    wb(tb_, 32'h0000_1234, 0, 1, 0);
    clear_in(); iss_valid_i = 1; iss_kind_i = 2'b00; step();
    chk("R8 flush pulse", flush_o, 1);
    chk("R8 redirect target", redirect_pc_o, 32'h1234);
    chk("R8 issue dropped, empty", count_o, 0);
    idle();
    chk("R8 younger not retired", rf_we_o | mem_we_o, 0);

    // plain store (R7)
    t = m_tail; issue(2'b01, 0);
    wb(t, 32'h55, 32'hABC, 0, 0);
    idle();
    chk("R7 store written", mem_we_o, 1);
    chk("R7 store address", mem_addr_o, 32'hABC);

    // correct branch: no write, no flush (R8)
    t = m_tail; issue(2'b10, 0);
    wb(t, 32'h99, 0, 0, 0);
    idle();
    chk("R8 correct branch no flush", flush_o, 0);
    chk("R8 correct branch freed", count_o, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int idx;
      clear_in();
      iss_valid_i = ($urandom % 3) != 0;
      iss_kind_i  = 2'($urandom % 3);
      iss_reg_i   = 5'($urandom);
      idx = $urandom % D;
      if (m_valid[idx] && !m_ready[idx] && ($urandom % 2)) begin
        wb_valid_i = 1; wb_tag_i = 3'(idx); wb_value_i = $urandom; wb_addr_i = $urandom;
        wb_mispredict_i = (m_kind[idx] == 2) && ($urandom % 4 == 0);
        wb_excp_i = ($urandom % 24) == 0;
      end
      look_tag_i[0] = 3'($urandom);
      look_tag_i[1] = 3'($urandom);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule